// File: doc/BRIEF.md
# Receive Character Framer with Line Pattern Monitors

This block sits after bit recovery in a modem receive path. The bit stream may come from any of the demodulators. The stream arrives one bit per `bit_strobe`, and the block samples no waveform itself. An asynchronous character receiver finds the start bit. It collects 5 to 8 data bits, least significant bit first. It then checks an optional parity bit and the stop bit, and it places the character in a receive data register. The register has ready, overrun, framing-error and parity-error flags.

Two monitors watch the same stream beside the receiver. The first reports a long run of alternating bits. The second reports a long run of identical bits, with separate flags for ones and for zeros. A host-side agent reads the character and pulses `rd_strobe`. The monitor flags follow the line on their own and need no handshake.

Top module: `rx_line_monitor`

## Requirements
- R1: After reset every output is 0.
- R2: While idle, a 0 bit is a start bit. The data bits that follow are placed LSB first. `cfg_char_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data register bits above the character length read 0.
- R3: The clock edge that samples the strobe carrying the stop bit also loads `rx_data` and raises `rx_ready`.
- R4: When `cfg_parity_en` is 1, one parity bit follows the data. With `cfg_parity_odd` = 0 the data and parity together must hold an even number of ones; with 1, an odd number. A mismatch sets `rx_parity_err` for that character. When `cfg_parity_en` is 0 no parity bit is expected and `rx_parity_err` is 0.
- R5: A 0 in the stop position sets `rx_frame_err`. The character is still stored and `rx_ready` still rises. Each stored character rewrites both error flags.
- R6: After a framing error the receiver ignores 0 bits until it sees a 1. The next 0 after that 1 is a start bit.
- R7: A `rd_strobe` clears `rx_ready` and `rx_overrun` at the next edge.
- R8: If a character completes while `rx_ready` is 1 and no read arrives in the same cycle, `rx_overrun` sets. `rx_data` then holds the newer character.
- R9: `mon_alt` rises at the strobe of the 32nd bit in an unbroken run of alternating bits. It falls at the strobe of a bit that repeats its predecessor.
- R10: `mon_ones` and `mon_zeros` rise at the strobe of the 32nd identical 1 or 0. Each falls at the strobe of a differing bit.
- R11: The monitor flags change only at strobed edges. `mon_alt` is never 1 while `mon_ones` or `mon_zeros` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse marking a valid bit on `bit_in` |
| bit_in | input | 1 | Recovered, descrambled data bit |
| cfg_char_len | input | 2 | Data bits minus 5 |
| cfg_parity_en | input | 1 | Parity bit present and checked |
| cfg_parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_strobe | input | 1 | Host has read the data register |
| rx_data | output | 8 | Receive data register |
| rx_ready | output | 1 | Unread character present |
| rx_overrun | output | 1 | A character replaced an unread one |
| rx_frame_err | output | 1 | Last character had a 0 stop bit |
| rx_parity_err | output | 1 | Last character failed parity |
| mon_alt | output | 1 | Long alternating run seen |
| mon_ones | output | 1 | Long run of ones seen |
| mon_zeros | output | 1 | Long run of zeros seen |

## Verification
Every result is registered once, so each one is due one clock after its cause. The data register, ready flag and both error flags follow the edge that samples the stop-bit strobe. The monitor flags follow the edge that samples the strobe of the deciding bit. The ready and overrun flags clear one edge after `rd_strobe`. The bench drives at falling edges and samples at the first falling edge after the deciding rising edge. A scoreboard compares each stored character there, and a per-bit reference model of run lengths is compared against the monitor flags after every strobe.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
    localparam int CHAR_MAX = 8;
    localparam int CHAR_MIN = 5;
    localparam int IDX_W    = $clog2(CHAR_MAX);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HUNT
    } rx_state_e;

    typedef struct packed {
        rx_state_e             state;
        logic [IDX_W-1:0]      idx;
        logic [CHAR_MAX-1:0]   shreg;
        logic                  par_bit;
        logic [CHAR_MAX-1:0]   data;
        logic                  ready;
        logic                  overrun;
        logic                  ferr;
        logic                  perr;
    } rx_regs_t;
endpackage

// File: rtl/rxm_pattern_count.sv
module rxm_pattern_count #(
    parameter int LIMIT  = 32,
    parameter bit TOGGLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic bit_in,
    output logic hit,
    output logic last_bit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
        logic          have;
    } pc_regs_t;

    pc_regs_t q, d;
    logic     match;

    generate
        if (TOGGLE) begin : g_alt
            assign match = (bit_in != q.prev);
        end else begin : g_run
            assign match = (bit_in == q.prev);
        end
    endgenerate

    always_comb begin
        d = q;
        if (strobe) begin
            d.have = 1'b1;
            d.prev = bit_in;
            if (q.have && match) begin
                if (q.cnt != LIM_C) d.cnt = q.cnt + 1'b1;
            end else begin
                d.cnt = CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hit      = (q.cnt == LIM_C);
    assign last_bit = q.prev;

    // R11
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(q.cnt));
endmodule

// File: rtl/rxm_char_engine.sv
module rxm_char_engine
    import rxm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe,
    input  logic                bit_in,
    input  logic [1:0]          cfg_char_len,
    input  logic                cfg_parity_en,
    input  logic                cfg_parity_odd,
    input  logic                rd_strobe,
    output logic [CHAR_MAX-1:0] data,
    output logic                ready,
    output logic                overrun,
    output logic                frame_err,
    output logic                parity_err
);
    rx_regs_t         q, d;
    logic [IDX_W-1:0] last_idx;
    logic             par_expect;

    assign last_idx   = IDX_W'(cfg_char_len) + IDX_W'(CHAR_MIN - 1);
    assign par_expect = (^q.shreg) ^ cfg_parity_odd;

    always_comb begin
        d = q;
        if (rd_strobe) begin
            d.ready   = 1'b0;
            d.overrun = 1'b0;
        end
        if (strobe) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (!bit_in) begin
                        d.state = ST_DATA;
                        d.idx   = '0;
                        d.shreg = '0;
                    end
                end
                ST_DATA: begin
                    d.shreg[q.idx] = bit_in;
                    d.idx          = q.idx + 1'b1;
                    if (q.idx == last_idx)
                        d.state = cfg_parity_en ? ST_PAR : ST_STOP;
                end
                ST_PAR: begin
                    d.par_bit = bit_in;
                    d.state   = ST_STOP;
                end
                ST_STOP: begin
                    d.data  = q.shreg;
                    d.ready = 1'b1;
                    if (q.ready && !rd_strobe) d.overrun = 1'b1;
                    d.ferr  = !bit_in;
                    d.perr  = cfg_parity_en && (q.par_bit != par_expect);
                    d.state = bit_in ? ST_IDLE : ST_HUNT;
                end
                ST_HUNT: begin
                    if (bit_in) d.state = ST_IDLE;
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data       = q.data;
    assign ready      = q.ready;
    assign overrun    = q.overrun;
    assign frame_err  = q.ferr;
    assign parity_err = q.perr;

    // R3
    ready_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ready) |-> $past(strobe));
    // R8
    overrun_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.overrun) |-> $past(q.ready));
    // R6
    hunt_ignores_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HUNT && strobe && !bit_in) |=> (q.state == ST_HUNT));
endmodule

// File: rtl/rx_line_monitor.sv
module rx_line_monitor #(
    parameter int ALT_LEN = 32,
    parameter int RUN_LEN = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_strobe,
    input  logic       bit_in,
    input  logic [1:0] cfg_char_len,
    input  logic       cfg_parity_en,
    input  logic       cfg_parity_odd,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       rx_overrun,
    output logic       rx_frame_err,
    output logic       rx_parity_err,
    output logic       mon_alt,
    output logic       mon_ones,
    output logic       mon_zeros
);
    logic alt_hit, alt_last, run_hit, run_last;

    rxm_char_engine i_char (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe         (bit_strobe),
        .bit_in         (bit_in),
        .cfg_char_len   (cfg_char_len),
        .cfg_parity_en  (cfg_parity_en),
        .cfg_parity_odd (cfg_parity_odd),
        .rd_strobe      (rd_strobe),
        .data           (rx_data),
        .ready          (rx_ready),
        .overrun        (rx_overrun),
        .frame_err      (rx_frame_err),
        .parity_err     (rx_parity_err)
    );

    rxm_pattern_count #(.LIMIT(ALT_LEN), .TOGGLE(1'b1)) i_alt (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bit_strobe),
        .bit_in   (bit_in),
        .hit      (alt_hit),
        .last_bit (alt_last)
    );

    rxm_pattern_count #(.LIMIT(RUN_LEN), .TOGGLE(1'b0)) i_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (bit_strobe),
        .bit_in   (bit_in),
        .hit      (run_hit),
        .last_bit (run_last)
    );

    assign mon_alt   = alt_hit;
    assign mon_ones  = run_hit & run_last;
    assign mon_zeros = run_hit & ~run_last;

    logic unused_alt_last;
    assign unused_alt_last = alt_last;

    // R11
    monitors_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(alt_hit && run_hit));
endmodule

// File: tb/test_rx_line_monitor.sv
module test_rx_line_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_strobe = 1'b0;
    logic       bit_in = 1'b1;
    logic [1:0] cfg_char_len = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_odd = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_overrun, rx_frame_err, rx_parity_err;
    logic       mon_alt, mon_ones, mon_zeros;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit auto_read = 1;

    logic [9:0] exp_q[$];

    int  m_alt = 0, m_run = 0;
    bit  m_have = 0;
    logic m_prev = 1'b0;

    always #5 clk = ~clk;

    rx_line_monitor i_rx_line_monitor (
        .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .bit_in(bit_in),
        .cfg_char_len(cfg_char_len), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_odd(cfg_parity_odd), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .mon_alt(mon_alt), .mon_ones(mon_ones), .mon_zeros(mon_zeros)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R9 R10 reference model of run lengths, checked after every strobe
    task automatic send_bit(logic b);
        @(negedge clk);
        bit_in = b;
        bit_strobe = 1'b1;
        @(negedge clk);
        bit_strobe = 1'b0;
        if (m_have && b != m_prev) m_alt = (m_alt < 32) ? m_alt + 1 : 32;
        else m_alt = 1;
        if (m_have && b == m_prev) m_run = (m_run < 32) ? m_run + 1 : 32;
        else m_run = 1;
        m_have = 1;
        m_prev = b;
        chk("R9 mon_alt", mon_alt, m_alt == 32);
        chk("R10 mon_ones", mon_ones, m_run == 32 && b);
        chk("R10 mon_zeros", mon_zeros, m_run == 32 && !b);
        @(negedge clk);
    endtask

    task automatic send_char(logic [7:0] dat, int len, bit par_en, bit odd,
                             bit bad_par, bit bad_stop, bit push);
        logic [7:0] m;
        logic       p;
        m = dat & ((8'd1 << len) - 8'd1);
        cfg_char_len = 2'(len - 5);
        cfg_parity_en = par_en;
        cfg_parity_odd = odd;
        if (push) exp_q.push_back({m, bad_stop, par_en & bad_par});
        send_bit(1'b0);
        for (int i = 0; i < len; i++) send_bit(m[i]);
        if (par_en) begin
            p = (^m) ^ odd ^ bad_par;
            send_bit(p);
        end
        send_bit(!bad_stop);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    // scoreboard monitor: pops expected characters as the design stores them
    initial begin
        logic [9:0] e;
        forever begin
            @(negedge clk);
            if (auto_read && rd_strobe) rd_strobe = 1'b0;
            else if (auto_read && rst_n && rx_ready) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected character", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk("R2 R3 rx_data", rx_data, e[9:2]);
                    chk("R5 rx_frame_err", rx_frame_err, e[1]);
                    chk("R4 rx_parity_err", rx_parity_err, e[0]);
                end
                rd_strobe = 1'b1;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 flags", {rx_ready, rx_overrun, rx_frame_err, rx_parity_err,
                         mon_alt, mon_ones, mon_zeros}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 idle ones run
        for (int i = 0; i < 40; i++) send_bit(1'b1);

        // R2 R3 eight-bit characters, no parity
        send_char(8'hA5, 8, 0, 0, 0, 0, 1);
        send_char(8'h3C, 8, 0, 0, 0, 0, 1);
        // R2 short characters
        send_char(8'hF5, 5, 0, 0, 0, 0, 1);
        send_char(8'hDA, 7, 0, 0, 0, 0, 1);
        send_char(8'h2B, 6, 0, 0, 0, 0, 1);
        // R4 parity
        send_char(8'h81, 8, 1, 0, 0, 0, 1);
        send_char(8'h81, 8, 1, 1, 0, 0, 1);
        send_char(8'h07, 8, 1, 0, 1, 0, 1);
        send_char(8'h13, 7, 1, 1, 1, 0, 1);
        // R5 framing error
        send_char(8'h55, 8, 0, 0, 0, 1, 1);
        // R6 zeros after a framing error are ignored
        for (int i = 0; i < 12; i++) send_bit(1'b0);
        chk("R6 no frame while hunting", rx_ready, 0);
        send_bit(1'b1);
        send_char(8'h6E, 8, 0, 0, 0, 0, 1);
        send_bit(1'b1);
        chk("R6 queue drained", exp_q.size(), 0);

        // R8 overrun, then R7 read clear
        auto_read = 0;
        send_char(8'h11, 8, 0, 0, 0, 0, 0);
        chk("R3 ready held", rx_ready, 1);
        chk("R8 no overrun yet", rx_overrun, 0);
        send_char(8'h22, 8, 0, 0, 0, 0, 0);
        chk("R8 rx_overrun", rx_overrun, 1);
        chk("R8 newer data kept", rx_data, 8'h22);
        do_read();
        chk("R7 ready cleared", rx_ready, 0);
        chk("R7 overrun cleared", rx_overrun, 0);

        // R9 alternating run, then a break
        for (int i = 0; i < 40; i++) send_bit(i[0]);
        send_bit(m_prev);
        // R10 zero run, then a break
        for (int i = 0; i < 36; i++) send_bit(1'b0);
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        do_read();
        chk("R7 ready cleared after monitor runs", rx_ready, 0);
        auto_read = 1;
        send_char(8'hC3, 8, 0, 0, 0, 0, 1);
        send_bit(1'b1);
        chk("R3 final queue drained", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule